// File: doc/BRIEF.md
# Addressable Serial Slave with Chain and Shared-Bus Modes

This block is the serial front end of a peripheral that shares one SPI controller with up to three identical neighbours. A strap input chooses how the devices are wired. With the strap low they form a daisy chain: each device's chain output drives the next device's serial input. With the strap high they share one bus: all serial inputs are tied together, and all bus outputs are tied together behind tristate pads. Every chip-select frame opens with a header byte. Every device shifts that byte in and forwards it, so all devices decode the same header. Only the device whose identity straps match the header then takes part in the exchange.

The header byte holds three fields. Bits 7:6 give the target identity. Bit 5 is the direction (1 = read, 0 = write). Bits 4:0 give the register address. For a read, the selected device fetches one register through a parallel port and shifts it out, MSB first, in the byte after the header. For a write, the byte after the header is handed to device logic with a single-cycle strobe. SPI mode 0 is used. SCK, chip select and data are oversampled by the block clock through a synchronizer.

Top module: `spiAddrSlave`

## Requirements
- R1: While reset is held and just after it is released, soc, sob, sobOe, regRdStb and regWrStb are all 0.
- R2: In chain mode (busMode=0) a device that is not addressed copies each serial bit to soc. The bit sampled at a rising SCK edge appears after the following falling edge. This holds for the header and for every later byte. Before the first falling edge of a frame, soc is 0.
- R3: A header bit is taken at each rising SCK edge, MSB first. After the eighth rising edge, regAddr shows header bits 4:0. The device is addressed when header bits 7:6 equal devId. Header bit 5 set to 1 means read.
- R4: For an addressed read in chain mode, regRdStb pulses for exactly one clock after the eighth rising edge. regRdData is taken in the clock after that pulse. The register then appears on soc, MSB first. Its first bit appears after the falling edge that follows the eighth rising edge, and one new bit appears after each of the next seven falling edges.
- R5: In bus mode, soc stays 0. sobOe is 1 only for an addressed read, over the same eight bit times as in R4, and during that window sob carries the register MSB first. At all other times sobOe and sob are 0, including for a device that is not addressed.
- R6: In chain mode, sobOe stays 0 in every frame.
- R7: For an addressed write, regWrStb pulses for exactly one clock after the sixteenth rising edge. At that clock, regWrData holds the second byte and regAddr holds the header address. There is no write strobe for a read, or for a device that is not addressed.
- R8: Once the data byte ends, an addressed device acts like one that is not addressed. In chain mode it forwards bits again as in R2. In bus mode it drops sobOe.
- R9: Raising csN at any point ends the frame. A few clocks later soc, sob and sobOe are 0. A write whose byte is incomplete is never strobed. The next frame starts again with a header byte.
- R10: For an addressed write in chain mode, soc is 0 during the eight bit times of the data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, idle low |
| csN | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data in |
| busMode | input | 1 | Wiring strap: 0 chain, 1 shared bus |
| devId | input | 2 | Identity straps compared with header bits 7:6 |
| soc | output | 1 | Chain output toward the next device |
| sob | output | 1 | Bus output data |
| sobOe | output | 1 | Bus output enable for the tristate pad |
| regAddr | output | 5 | Register address from the header |
| regRdStb | output | 1 | One-clock read request |
| regRdData | input | 8 | Read data, valid in the clock after regRdStb |
| regWrStb | output | 1 | One-clock write strobe |
| regWrData | output | 8 | Write data |

## Verification
A serial edge reaches the outputs about three block clocks after it is driven: two synchronizer stages, then one register. The bench holds each SCK level for eight clocks and samples soc, sob and sobOe in the last clock before the next edge. The behavioural model gives the value due after each falling edge, so every bit time is compared while the value is stable. Read and write strobes arrive one clock after the synchronized rising edge. A monitor counts them on every clock, and the counts, address and data are checked once each frame has ended.

// File: rtl/spiAddrSlavePkg.sv
package spiAddrSlavePkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA,
    ST_PASS
  } slvState_e;

  typedef enum logic [1:0] {
    OUT_PASS,
    OUT_TX,
    OUT_ZERO
  } outSel_e;

  typedef struct packed {
    logic    clear;
    logic    shiftIn;
    logic    hdrLatch;
    logic    wrLatch;
    logic    txLoad;
    logic    fallUpd;
    outSel_e outSel;
  } ctrlStb_t;

endpackage

// File: rtl/spiPinSync.sv
module spiPinSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic csNIn,
  input  logic sdiIn,
  output logic sckRise,
  output logic sckFall,
  output logic csActive,
  output logic sdiS
);

  logic [STAGES-1:0] sckP;
  logic [STAGES-1:0] csP;
  logic [STAGES-1:0] sdiP;
  logic              sckLast;

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sckP[g] <= 1'b0;
          csP[g]  <= 1'b1;
          sdiP[g] <= 1'b0;
        end else begin
          sckP[g] <= sckIn;
          csP[g]  <= csNIn;
          sdiP[g] <= sdiIn;
        end
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sckP[g] <= 1'b0;
          csP[g]  <= 1'b1;
          sdiP[g] <= 1'b0;
        end else begin
          sckP[g] <= sckP[g-1];
          csP[g]  <= csP[g-1];
          sdiP[g] <= sdiP[g-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckLast <= 1'b0;
    else       sckLast <= sckP[STAGES-1];
  end

  assign sckRise  = sckP[STAGES-1] & ~sckLast;
  assign sckFall  = ~sckP[STAGES-1] & sckLast;
  assign csActive = ~csP[STAGES-1];
  assign sdiS     = sdiP[STAGES-1];

endmodule

// File: rtl/spiSlvCtrl.sv
module spiSlvCtrl
  import spiAddrSlavePkg::*;
#(
  parameter int ID_W   = 2,
  parameter int HDR_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csActive,
  input  logic            sckRise,
  input  logic            sckFall,
  input  logic [ID_W-1:0] devId,
  input  logic [ID_W-1:0] hdrId,
  input  logic            hdrRd,
  output ctrlStb_t        stb,
  output logic            rdStb,
  output logic            wrStb
);

  localparam int RX_W  = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int CNT_W = $clog2(RX_W);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  slvState_e        state;
  logic [CNT_W-1:0] bitCnt;
  logic             isRead;
  logic             rdStbD;
  logic             active;
  logic             hdrDone;
  logic             dataDone;
  logic             hit;

  assign active   = csActive && (state != ST_IDLE);
  assign hdrDone  = (state == ST_HDR) && (bitCnt == HDR_LAST);
  assign dataDone = (state == ST_DATA) && (bitCnt == DATA_LAST);
  assign hit      = (hdrId == devId);

  always_comb begin
    stb          = '0;
    stb.clear    = ~csActive;
    stb.shiftIn  = active && sckRise;
    stb.hdrLatch = active && sckRise && hdrDone;
    stb.wrLatch  = active && sckRise && dataDone && !isRead;
    stb.txLoad   = rdStbD;
    stb.fallUpd  = active && sckFall;
    if (state == ST_DATA) stb.outSel = isRead ? OUT_TX : OUT_ZERO;
    else                  stb.outSel = OUT_PASS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      isRead <= 1'b0;
      rdStb  <= 1'b0;
      rdStbD <= 1'b0;
      wrStb  <= 1'b0;
    end else begin
      rdStb  <= 1'b0;
      wrStb  <= 1'b0;
      rdStbD <= rdStb;
      if (!csActive) begin
        state  <= ST_IDLE;
        bitCnt <= '0;
        isRead <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            state  <= ST_HDR;
            bitCnt <= '0;
          end
          ST_HDR: begin
            if (sckRise) begin
              if (hdrDone) begin
                bitCnt <= '0;
                if (hit) begin
                  state  <= ST_DATA;
                  isRead <= hdrRd;
                  rdStb  <= hdrRd;
                end else begin
                  state <= ST_PASS;
                end
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end
          ST_DATA: begin
            if (sckRise) begin
              if (dataDone) begin
                bitCnt <= '0;
                state  <= ST_PASS;
                wrStb  <= !isRead;
              end else begin
                bitCnt <= bitCnt + 1'b1;
              end
            end
          end
          default: state <= ST_PASS;
        endcase
      end
    end
  end

endmodule

// File: rtl/spiSlvDatapath.sv
module spiSlvDatapath
  import spiAddrSlavePkg::*;
#(
  parameter int ID_W   = 2,
  parameter int ADR_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              sdiS,
  input  logic              busMode,
  input  logic [DATA_W-1:0] rdData,
  output logic [ID_W-1:0]   hdrId,
  output logic              hdrRd,
  output logic [ADR_W-1:0]  regAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              soc,
  output logic              sob,
  output logic              sobOe
);

  localparam int HDR_W = ID_W + 1 + ADR_W;
  localparam int RX_W  = (HDR_W > DATA_W) ? HDR_W : DATA_W;

  logic [RX_W-1:0]   rxShift;
  logic [RX_W-1:0]   rxNext;
  logic [DATA_W-1:0] txShift;
  logic              outBit;
  logic              oe;

  assign rxNext = {rxShift[RX_W-2:0], sdiS};
  assign hdrId  = rxNext[HDR_W-1 -: ID_W];
  assign hdrRd  = rxNext[ADR_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      regAddr <= '0;
      wrData  <= '0;
    end else begin
      if (stb.clear)    rxShift <= '0;
      else if (stb.shiftIn) rxShift <= rxNext;
      if (stb.hdrLatch) regAddr <= rxNext[ADR_W-1:0];
      if (stb.wrLatch)  wrData  <= rxNext[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      outBit  <= 1'b0;
      oe      <= 1'b0;
    end else if (stb.clear) begin
      txShift <= '0;
      outBit  <= 1'b0;
      oe      <= 1'b0;
    end else begin
      if (stb.txLoad) begin
        txShift <= rdData;
      end else if (stb.fallUpd) begin
        case (stb.outSel)
          OUT_TX: begin
            outBit  <= txShift[DATA_W-1];
            txShift <= {txShift[DATA_W-2:0], 1'b0};
            oe      <= 1'b1;
          end
          OUT_ZERO: begin
            outBit <= 1'b0;
            oe     <= 1'b0;
          end
          default: begin
            outBit <= rxShift[0];
            oe     <= 1'b0;
          end
        endcase
      end
    end
  end

  assign soc   = busMode ? 1'b0 : outBit;
  assign sobOe = busMode & oe;
  assign sob   = sobOe & outBit;

endmodule

// File: rtl/spiAddrSlave.sv
module spiAddrSlave
  import spiAddrSlavePkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int ID_W        = 2,
  parameter int ADR_W       = 5,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sck,
  input  logic              csN,
  input  logic              sdi,
  input  logic              busMode,
  input  logic [ID_W-1:0]   devId,
  output logic              soc,
  output logic              sob,
  output logic              sobOe,
  output logic [ADR_W-1:0]  regAddr,
  output logic              regRdStb,
  input  logic [DATA_W-1:0] regRdData,
  output logic              regWrStb,
  output logic [DATA_W-1:0] regWrData
);

  localparam int HDR_W = ID_W + 1 + ADR_W;

  logic            sckRise;
  logic            sckFall;
  logic            csActive;
  logic            sdiS;
  logic [ID_W-1:0] hdrId;
  logic            hdrRd;
  ctrlStb_t        stb;

  spiPinSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sckIn(sck), .csNIn(csN), .sdiIn(sdi),
    .sckRise(sckRise), .sckFall(sckFall), .csActive(csActive), .sdiS(sdiS)
  );

  spiSlvCtrl #(.ID_W(ID_W), .HDR_W(HDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .csActive(csActive), .sckRise(sckRise),
    .sckFall(sckFall), .devId(devId), .hdrId(hdrId), .hdrRd(hdrRd),
    .stb(stb), .rdStb(regRdStb), .wrStb(regWrStb)
  );

  spiSlvDatapath #(.ID_W(ID_W), .ADR_W(ADR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdiS(sdiS), .busMode(busMode),
    .rdData(regRdData), .hdrId(hdrId), .hdrRd(hdrRd), .regAddr(regAddr),
    .wrData(regWrData), .soc(soc), .sob(sob), .sobOe(sobOe)
  );

endmodule

// File: rtl/spiAddrSlaveChk.sv
module spiAddrSlaveChk (
  input logic clk,
  input logic rstN,
  input logic csActive,
  input logic sobOe,
  input logic rdStb,
  input logic wrStb
);

  // R9
  abort_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> !sobOe);

  // R4
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdStb |=> !rdStb);

  // R7
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> !wrStb);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStb && wrStb));

endmodule

bind spiAddrSlave spiAddrSlaveChk uChk (
  .clk(clk), .rstN(rstN), .csActive(csActive), .sobOe(sobOe),
  .rdStb(regRdStb), .wrStb(regWrStb)
);

// File: tb/sim_spiAddrSlave.sv
module sim_spiAddrSlave;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sck = 1'b0;
  logic       csN = 1'b1;
  logic       sdi = 1'b0;
  logic       busMode = 1'b0;
  logic [1:0] devId = 2'd0;
  logic       soc, sob, sobOe;
  logic [4:0] regAddr;
  logic       regRdStb, regWrStb;
  logic [7:0] regRdData = 8'h00;
  logic [7:0] regWrData;

  int  total = 0;
  int  bad = 0;
  int  rdCount = 0;
  int  wrCount = 0;
  bit  finished = 0;
  logic [7:0] mem [32];

  localparam int HALF = 8;

  always #10 clk = ~clk;

  spiAddrSlave u0 (
    .clk(clk), .rstN(rstN), .sck(sck), .csN(csN), .sdi(sdi),
    .busMode(busMode), .devId(devId), .soc(soc), .sob(sob), .sobOe(sobOe),
    .regAddr(regAddr), .regRdStb(regRdStb), .regRdData(regRdData),
    .regWrStb(regWrStb), .regWrData(regWrData)
  );

  // device-side register model
  always @(posedge clk) begin
    if (regRdStb) begin
      regRdData <= mem[regAddr];
      rdCount   <= rdCount + 1;
    end
    if (regWrStb) begin
      mem[regAddr] <= regWrData;
      wrCount      <= wrCount + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkOuts(input string req, input bit eSoc, input bit eSob,
                           input bit eOe);
    chk(req, soc, eSoc);
    chk(req, sob, eSob);
    chk(req, sobOe, eOe);
  endtask

  // expected outputs after falling edge idx of a frame
  task automatic checkFall(input int idx, input logic [23:0] stream,
                           input bit hitDev, input bit isRd,
                           input logic [7:0] rdVal);
    bit inData;
    bit eSoc, eSob, eOe;
    string req;
    if (idx < 0) begin
      checkOuts("R2", 1'b0, 1'b0, 1'b0);
      return;
    end
    inData = hitDev && idx >= 7 && idx <= 14;
    if (busMode) begin
      eSoc = 1'b0;
      eOe  = inData && isRd;
      eSob = eOe ? rdVal[14-idx] : 1'b0;
      req  = (hitDev && idx > 14) ? "R8" : "R5";
    end else begin
      eOe = 1'b0;
      eSob = 1'b0;
      if (inData) eSoc = isRd ? rdVal[14-idx] : 1'b0;
      else        eSoc = stream[23-idx];
      if (inData && isRd)      req = "R4";
      else if (inData)         req = "R10";
      else if (hitDev && idx > 14) req = "R8";
      else                     req = "R2";
      chk("R6", sobOe, 0);
    end
    checkOuts(req, eSoc, eSob, eOe);
  endtask

  task automatic runFrame(input logic [7:0] hdr, input logic [7:0] dat,
                          input int nBits);
    logic [23:0] stream;
    bit hitDev, isRd;
    logic [7:0] rdVal;
    int rd0, wr0;
    logic [7:0] oldMem;
    stream = {hdr, dat, 8'hA5};
    hitDev = (hdr[7:6] == devId);
    isRd   = hdr[5];
    rdVal  = mem[hdr[4:0]];
    oldMem = mem[hdr[4:0]];
    rd0 = rdCount;
    wr0 = wrCount;
    csN = 1'b0;
    for (int j = 0; j < nBits; j++) begin
      sdi = stream[23-j];
      repeat (HALF) @(negedge clk);
      checkFall(j - 1, stream, hitDev, isRd, rdVal);
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    checkFall(nBits - 1, stream, hitDev, isRd, rdVal);
    csN = 1'b1;
    repeat (HALF) @(negedge clk);
    checkOuts("R9", 1'b0, 1'b0, 1'b0);
    if (nBits >= 8) chk("R3", regAddr, hdr[4:0]);
    chk("R4", rdCount - rd0, (hitDev && isRd && nBits >= 8) ? 1 : 0);
    chk("R7", wrCount - wr0, (hitDev && !isRd && nBits >= 16) ? 1 : 0);
    if (hitDev && !isRd && nBits >= 16) chk("R7", mem[hdr[4:0]], dat);
    else if (!isRd) chk("R9", mem[hdr[4:0]], oldMem);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 8'((i * 37 + 5) ^ 8'h5A);
    repeat (3) @(negedge clk);
    checkOuts("R1", 1'b0, 1'b0, 1'b0);
    chk("R1", regRdStb, 0);
    chk("R1", regWrStb, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    checkOuts("R1", 1'b0, 1'b0, 1'b0);
    chk("R1", regWrStb, 0);

    // chain mode, identity 1
    busMode = 1'b0; devId = 2'd1;
    runFrame({2'd2, 1'b1, 5'd3}, 8'h00, 24);   // R2 not addressed
    runFrame({2'd1, 1'b1, 5'd5}, 8'h00, 24);   // R4 / R8
    runFrame({2'd1, 1'b0, 5'd9}, 8'h3C, 16);   // R7 / R10
    runFrame({2'd1, 1'b1, 5'd9}, 8'h00, 16);   // R4 readback

    // bus mode, identity 3
    busMode = 1'b1; devId = 2'd3;
    runFrame({2'd3, 1'b1, 5'd9}, 8'h00, 24);   // R5 / R8
    runFrame({2'd0, 1'b1, 5'd9}, 8'h00, 16);   // R5 not addressed
    runFrame({2'd3, 1'b0, 5'd31}, 8'h81, 16);  // R7
    runFrame({2'd3, 1'b1, 5'd4}, 8'h00, 11);   // R9 abort in read
    runFrame({2'd3, 1'b0, 5'd2}, 8'hF0, 13);   // R9 abort in write
    runFrame({2'd3, 1'b1, 5'd31}, 8'h00, 16);  // R9 recovery, reads 81

    // chain mode, write to another identity
    busMode = 1'b0; devId = 2'd0;
    runFrame({2'd2, 1'b0, 5'd7}, 8'h99, 16);   // R7 no strobe
    runFrame({2'd0, 1'b1, 5'd2}, 8'h00, 5);    // R9 abort in header

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule